// File: doc/BRIEF.md
# Legacy Interrupt Line Status and Enable Register

This block gathers four level-sensitive legacy interrupt lines into one 32-bit control word. The lines are named INTA, INTB, INTC and INTD, with INTA as line 0. Each line has a sticky pending flag that software clears by writing one to it. Each line also has an enable bit. The block drives one combined interrupt request toward a parent interrupt controller. It also reports the index of the lowest-numbered line that is both pending and enabled, which matches the order in which a handler walks the lines.

The same word holds other settings that neighbouring logic uses: enables for eight bus error events, seven requester priority selects and a four-bit ready-wait setting. They are written through the same byte-laned port and brought out as plain outputs. This block does not act on them.

Writes take effect on the next rising clock edge. Reads are combinational from the stored state. Reset is synchronous and active high.

Top module: `intx_ctrl_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every stored bit clears. After that edge `reg_rdata` reads 0 and `irq_out` is low, even if interrupt lines are held high during reset.
- R2: A pending flag (bit 28+i, line i, INTA at bit 28) sets at each edge where `irq_lines[i]` is high, whether or not the line is enabled. It then stays set after the line falls.
- R3: A write with `reg_be[3]` set clears every pending flag whose data bit in 31..28 is one. A zero leaves the flag as it was. The clear wins over a line that is still high at that edge, and the flag sets again at the next edge if the line stays high.
- R4: Bit 22+i enables line i (INTA at bit 22). A set bit enables the line. `irq_out` is high exactly when some line is both pending and enabled.
- R5: `irq_id` is the 2-bit index of the lowest-numbered line that is both pending and enabled (INTA=0 … INTD=3). It is 0 when no line qualifies.
- R6: Only the byte lanes selected by `reg_be` change on a write (lane k covers bits 8k+7..8k). Without a write, bits 27..0 hold their value. The side fields are as follows. `err_en` is {bit27, bit26, bits21..16}. `prio_sel` is bits 14..8. `trdy_wait` is bits 3..0.
- R7: Bit 15 and bits 7..4 ignore writes and always read as zero.
- R8: A write of 0xF000_0000 with `reg_be`=4'b1100 does three things at once. It clears all four pending flags, disables all four lines, and clears every error-event enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| irq_lines | input | 4 | Level interrupt inputs, bit 0 = INTA |
| irq_out | output | 1 | Combined interrupt request |
| irq_id | output | 2 | Lowest pending enabled line |
| err_en | output | 8 | Error-event enables |
| prio_sel | output | 7 | Requester priority selects |
| trdy_wait | output | 4 | Ready-wait setting |

## Verification
The hardest case to reach is a clear that meets a line still held high. The flag must drop for exactly one cycle and then come back. To reach it, the stimulus holds INTC high across the write-one-to-clear. It then keeps the line high with no write and checks that the flag has set again. The stimulus also masks a line that is still pending, so that `irq_out` falls while the status bit stays visible. It sets a pending flag on a disabled line and enables it later, so that the request appears only when the enable arrives. The ordering of `irq_id` is checked with INTA and INTD pending together, and again after INTA has been cleared.

// File: rtl/intx_pkg.sv
package intx_pkg;

    localparam int REG_W       = 32;
    localparam int LANE_W      = 8;
    localparam int LANES       = REG_W / LANE_W;
    localparam int NUM_LINES   = 4;
    localparam int LINE_ID_W   = $clog2(NUM_LINES);

    // Field positions decoded by neighbouring logic and by software
    localparam int STS_LSB     = 28;
    localparam int EN_LSB      = 22;
    localparam int CMD_ERR_BIT = 27;
    localparam int PAR_ERR_BIT = 26;
    localparam int BUS_ERR_LSB = 16;
    localparam int BUS_ERR_W   = 6;
    localparam int PRIO_LSB    = 8;
    localparam int PRIO_W      = 7;
    localparam int WAIT_LSB    = 0;
    localparam int WAIT_W      = 4;
    localparam int ERR_W       = 2 + BUS_ERR_W;

    typedef logic [REG_W-1:0]     word_t;
    typedef logic [NUM_LINES-1:0] lines_t;

    typedef struct packed {
        logic [ERR_W-1:0]  err_en;
        logic [PRIO_W-1:0] prio;
        logic [WAIT_W-1:0] wait_cyc;
    } side_cfg_t;

    // Bits held by the configuration store (everything except status and reserved)
    function automatic word_t cfg_wmask();
        word_t m;
        m = '0;
        for (int i = 0; i < NUM_LINES; i++) m[EN_LSB + i] = 1'b1;
        m[CMD_ERR_BIT] = 1'b1;
        m[PAR_ERR_BIT] = 1'b1;
        for (int i = 0; i < BUS_ERR_W; i++) m[BUS_ERR_LSB + i] = 1'b1;
        for (int i = 0; i < PRIO_W; i++)    m[PRIO_LSB + i]    = 1'b1;
        for (int i = 0; i < WAIT_W; i++)    m[WAIT_LSB + i]    = 1'b1;
        return m;
    endfunction

    function automatic int lane_of(int bit_pos);
        return bit_pos / LANE_W;
    endfunction

    function automatic side_cfg_t unpack_side(word_t w);
        side_cfg_t s;
        s.err_en   = {w[CMD_ERR_BIT], w[PAR_ERR_BIT], w[BUS_ERR_LSB +: BUS_ERR_W]};
        s.prio     = w[PRIO_LSB +: PRIO_W];
        s.wait_cyc = w[WAIT_LSB +: WAIT_W];
        return s;
    endfunction

    function automatic word_t merge_view(word_t cfg, lines_t sts);
        return cfg | (word_t'(sts) << STS_LSB);
    endfunction

endpackage

// File: rtl/intx_cfg_store.sv
module intx_cfg_store
    import intx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    input  word_t            wdata,
    output word_t            cfg_q
);

    localparam word_t WMASK = cfg_wmask();

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (be[l]) begin
                    cfg_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W] & WMASK[l*LANE_W +: LANE_W];
                end
            end
        end
    end

endmodule

// File: rtl/intx_status_bank.sv
module intx_status_bank
    import intx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t clr,
    input  lines_t lines,
    output lines_t sts_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (clr[i])        sts_q[i] <= 1'b0;
                else if (lines[i]) sts_q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/intx_irq_combine.sv
module intx_irq_combine
    import intx_pkg::*;
(
    input  lines_t               sts,
    input  lines_t               en,
    output logic                 irq,
    output logic [LINE_ID_W-1:0] id
);

    lines_t pend;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pend
        assign pend[g] = sts[g] & en[g];
    end

    assign irq = |pend;

    always_comb begin
        id = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) id = LINE_ID_W'(i);
        end
    end

endmodule

// File: rtl/intx_ctrl_reg.sv
module intx_ctrl_reg
    import intx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [LANES-1:0]      reg_be,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_LINES-1:0]  irq_lines,
    output logic                  irq_out,
    output logic [LINE_ID_W-1:0]  irq_id,
    output logic [ERR_W-1:0]      err_en,
    output logic [PRIO_W-1:0]     prio_sel,
    output logic [WAIT_W-1:0]     trdy_wait
);

    word_t     cfg_q;
    lines_t    sts_q;
    lines_t    clr;
    lines_t    en;
    side_cfg_t side;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
        localparam int SBIT = STS_LSB + g;
        assign clr[g] = reg_wr & reg_be[lane_of(SBIT)] & reg_wdata[SBIT];
    end

    intx_cfg_store u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .be    (reg_be),
        .wdata (reg_wdata),
        .cfg_q (cfg_q)
    );

    intx_status_bank u_sts (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .lines (irq_lines),
        .sts_q (sts_q)
    );

    assign en = cfg_q[EN_LSB +: NUM_LINES];

    intx_irq_combine u_irq (
        .sts (sts_q),
        .en  (en),
        .irq (irq_out),
        .id  (irq_id)
    );

    assign side      = unpack_side(cfg_q);
    assign err_en    = side.err_en;
    assign prio_sel  = side.prio;
    assign trdy_wait = side.wait_cyc;
    assign reg_rdata = merge_view(cfg_q, sts_q);

endmodule

// File: rtl/intx_ctrl_reg_chk.sv
module intx_ctrl_reg_chk
    import intx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic                 be_top,
    input logic [NUM_LINES-1:0] clr_bits,
    input logic [REG_W-1:0]     reg_rdata,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 irq_out,
    input logic [LINE_ID_W-1:0] irq_id
);

    logic [NUM_LINES-1:0] pend_v;
    assign pend_v = reg_rdata[STS_LSB +: NUM_LINES] & reg_rdata[EN_LSB +: NUM_LINES];

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0) && !irq_out);

    // R4
    assert_irq_summary_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out == (pend_v != '0));

    // R5
    assert_lowest_id_R5: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> pend_v[irq_id] &&
                    ((pend_v & ((NUM_LINES'(1) << irq_id) - NUM_LINES'(1))) == '0));

    // R7
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[15] == 1'b0) && (reg_rdata[7:4] == 4'h0));

    // R6
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(reg_rdata[27:0]));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // R2
        assert_sticky_set_R2: assert property (@(posedge clk) disable iff (rst)
            (irq_lines[g] && !(reg_wr && be_top && clr_bits[g])) |=> reg_rdata[STS_LSB + g]);
        // R3
        assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && be_top && clr_bits[g]) |=> !reg_rdata[STS_LSB + g]);
    end

endmodule

bind intx_ctrl_reg intx_ctrl_reg_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .be_top    (reg_be[3]),
    .clr_bits  (reg_wdata[31:28]),
    .reg_rdata (reg_rdata),
    .irq_lines (irq_lines),
    .irq_out   (irq_out),
    .irq_id    (irq_id)
);

// File: tb/intx_ctrl_reg_tb.sv
module intx_ctrl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_lines = '0;
    logic        irq_out;
    logic [1:0]  irq_id;
    logic [7:0]  err_en;
    logic [6:0]  prio_sel;
    logic [3:0]  trdy_wait;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    intx_ctrl_reg dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_lines (irq_lines),
        .irq_out   (irq_out),
        .irq_id    (irq_id),
        .err_en    (err_en),
        .prio_sel  (prio_sel),
        .trdy_wait (trdy_wait)
    );

    typedef struct packed {
        logic [3:0]  lines;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [1:0]  exp_id;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 1'b1, 4'b1111, 32'h0FFF_FFFF, 32'h0FFF_7F0F, 1'b0, 2'd0}, // R6 R7 full write
        '{4'b0001, 1'b0, 4'b0000, 32'h0,         32'h1FFF_7F0F, 1'b1, 2'd0}, // R2 R4 INTA
        '{4'b1000, 1'b0, 4'b0000, 32'h0,         32'h9FFF_7F0F, 1'b1, 2'd0}, // R2 R5 sticky, lowest
        '{4'b0000, 1'b1, 4'b1000, 32'h1F00_0000, 32'h8FFF_7F0F, 1'b1, 2'd3}, // R3 R5 clear INTA
        '{4'b0000, 1'b1, 4'b1000, 32'h0D00_0000, 32'h8DFF_7F0F, 1'b0, 2'd0}, // R3 R4 mask INTD
        '{4'b0100, 1'b0, 4'b0000, 32'h0,         32'hCDFF_7F0F, 1'b1, 2'd2}, // R5 INTC
        '{4'b0100, 1'b1, 4'b1000, 32'h4D00_0000, 32'h8DFF_7F0F, 1'b0, 2'd0}, // R3 clear beats level
        '{4'b0100, 1'b0, 4'b0000, 32'h0,         32'hCDFF_7F0F, 1'b1, 2'd2}, // R3 re-set next cycle
        '{4'b0000, 1'b1, 4'b1100, 32'hF000_0000, 32'h0000_7F0F, 1'b0, 2'd0}, // R8 start-up write
        '{4'b0000, 1'b1, 4'b0001, 32'hFFFF_FF05, 32'h0000_7F05, 1'b0, 2'd0}, // R6 R7 lane 0 only
        '{4'b0010, 1'b0, 4'b0000, 32'h0,         32'h2000_7F05, 1'b0, 2'd0}, // R2 disabled line
        '{4'b0000, 1'b1, 4'b0100, 32'h0080_0000, 32'h2080_7F05, 1'b1, 2'd1}, // R4 R6 enable INTB
        '{4'b0000, 1'b1, 4'b1000, 32'hF000_0000, 32'h0080_7F05, 1'b0, 2'd0}  // R3 clear all
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] l, logic w, logic [3:0] b, logic [31:0] d);
        irq_lines = l;
        reg_wr    = w;
        reg_be    = b;
        reg_wdata = d;
    endtask

    initial begin
        // R1: reset with all lines high
        drive(4'b1111, 1'b0, 4'b0, 32'h0);
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", reg_rdata, 32'h0);
        check("R1 irq in reset", {31'h0, irq_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R2: flags set though all lines are disabled; R4: no request
        check("R2 flags set while disabled", reg_rdata, 32'hF000_0000);
        check("R4 no request when disabled", {31'h0, irq_out}, 32'h0);
        drive(4'b0000, 1'b1, 4'b1000, 32'hF000_0000);
        @(negedge clk);
        check("R3 clear all flags", reg_rdata, 32'h0);

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].lines, VECS[v].wr, VECS[v].be, VECS[v].wdata);
            @(negedge clk);
            check($sformatf("R4/R6 vector %0d rdata", v), reg_rdata, VECS[v].exp_rd);
            check($sformatf("R4 vector %0d irq_out", v), {31'h0, irq_out}, {31'h0, VECS[v].exp_irq});
            check($sformatf("R5 vector %0d irq_id", v), {30'h0, irq_id}, {30'h0, VECS[v].exp_id});
        end

        // R6: side fields at the ports
        drive(4'b0000, 1'b0, 4'b0, 32'h0);
        check("R6 prio_sel", {25'h0, prio_sel}, 32'h7F);
        check("R6 trdy_wait", {28'h0, trdy_wait}, 32'h5);
        check("R8 err_en cleared", {24'h0, err_en}, 32'h0);
        drive(4'b0000, 1'b1, 4'b1100, 32'h0C3F_0000);
        @(negedge clk);
        check("R6 err_en order", {24'h0, err_en}, 32'hFF);

        // R1: reset mid-run
        drive(4'b0000, 1'b0, 4'b0, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", reg_rdata, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule